// File: doc/BRIEF.md
# Shifted-Subtract Accumulator Unit

This block is the execute stage of one arithmetic operation: it takes a 16-bit operand, widens it to 32 bits, shifts it left by 0 to 16 places with zeros entering at the bottom, and subtracts the result from a 32-bit accumulator that it holds. Each operation happens in one cycle and is marked by a valid strobe. A mode input selects how the operand is widened: by copying its top bit (signed) or by adding zeros (unsigned). The same operation updates four status flags: zero, negative, carry and overflow.

A second mode input decides what happens when the subtraction overflows. With saturation off, the accumulator keeps the wrapped result and a small signed counter moves up for a positive overflow or down for a negative one. With saturation on, the accumulator is clamped to the largest positive or most negative value and the counter does not change. A load port writes the accumulator, the flags and the counter in one cycle. It is meant for test setup and for restoring state.

Top module: `acc_shsub`

## Requirements
- R1: While reset is asserted, and until the first enabled edge after reset is released, the accumulator, the flags flag_z, flag_n, flag_c and flag_v, and the overflow counter all read zero.
- R2: When ld_vld is high at a clock edge, the accumulator, the four flags and the counter take the ld_* values, whatever op_vld is doing.
- R3: When neither ld_vld nor op_vld is high at a clock edge, none of the outputs changes, even if the other inputs change.
- R4: The subtrahend is op_data widened to 32 bits, sign-extended when sext_en=1 and zero-extended when sext_en=0. It is then shifted left by op_shift with zeros filled in at the low end, and bits above bit 31 are discarded. An op_shift value above 16 is treated as 16.
- R5: When op_vld is high and ld_vld is low, the new accumulator is the old accumulator minus the subtrahend, modulo 2^32, unless R11 applies.
- R6: After an operation, flag_z is 1 exactly when the final accumulator is zero, and flag_n equals bit 31 of the final accumulator (after any saturation).
- R7: For a shift below 16, flag_c is set to 0 when the subtraction borrows (old accumulator below the subtrahend, both taken as unsigned) and to 1 otherwise.
- R8: For a shift of 16, flag_c becomes 0 on a borrow and keeps its previous value when there is no borrow.
- R9: Positive overflow means a non-negative accumulator, a negative subtrahend and a negative wrapped result. Negative overflow means a negative accumulator, a non-negative subtrahend and a non-negative wrapped result. On either kind, flag_v becomes 1. An operation never clears flag_v.
- R10: With sat_en=0, the 6-bit two's-complement counter ovf_cnt goes up by 1 on a positive overflow and down by 1 on a negative overflow, and wraps at its ends (31+1 gives -32).
- R11: With sat_en=1, a positive overflow leaves the accumulator at 0x7FFF_FFFF and a negative overflow leaves it at 0x8000_0000. The counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| op_vld | input | 1 | Performs a subtraction at this edge |
| op_data | input | 16 | Operand |
| op_shift | input | 5 | Left shift amount, 0 to 16 |
| sext_en | input | 1 | 1: sign-extend the operand, 0: zero-extend it |
| sat_en | input | 1 | 1: saturate on overflow, 0: wrap and count |
| ld_vld | input | 1 | Writes the load values into the state |
| ld_acc | input | 32 | Accumulator load value |
| ld_z | input | 1 | Zero flag load value |
| ld_n | input | 1 | Negative flag load value |
| ld_c | input | 1 | Carry flag load value |
| ld_v | input | 1 | Overflow flag load value |
| ld_ovc | input | 6 | Overflow counter load value |
| acc | output | 32 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry (no-borrow) flag |
| flag_v | output | 1 | Sticky overflow flag |
| ovf_cnt | output | 6 | Signed overflow counter |

## Verification
The bench sweeps every shift from 0 to 17, both extension modes and both overflow modes, using operands and accumulators chosen at the sign boundaries. Three mistakes get particular attention. A design that zero-extends a negative operand gives a wrong accumulator for operands of 0x8000 and above. One that treats a shift of 16 like any other shift sets the carry when it should keep the old value. One that saturates without checking the operand signs clamps results that did not overflow. The loaded counter values sit next to the wrap points, so a counter that saturates or has the wrong width shows up as a wrong ovf_cnt. A long chained run with no loads checks that flag_v stays set and that Z and N follow the saturated value rather than the wrapped one.

// File: rtl/acc_shsub_pkg.sv
package acc_shsub_pkg;

  typedef enum logic [1:0] {
    OVF_NONE = 2'b00,
    OVF_POS  = 2'b01,
    OVF_NEG  = 2'b10
  } ovf_kind_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/acc_shsub_shaper.sv
module acc_shsub_shaper #(
  parameter int ACC_W = 32,
  parameter int OPD_W = 16,
  parameter int SH_W  = 5
) (
  input  logic [OPD_W-1:0] opd,
  input  logic [SH_W-1:0]  shift,
  input  logic             sext_en,
  output logic [ACC_W-1:0] shifted,
  output logic             sh_full
);

  localparam logic [SH_W-1:0] SH_MAX = SH_W'(OPD_W);

  logic [ACC_W-1:0] ext;
  logic [SH_W-1:0]  sh_amt;

  assign ext[OPD_W-1:0] = opd;

  // upper bits copy the operand sign only in sign-extension mode
  generate
    for (genvar i = OPD_W; i < ACC_W; i++) begin : g_ext
      assign ext[i] = sext_en & opd[OPD_W-1];
    end
  endgenerate

  always_comb begin
    sh_amt  = (shift > SH_MAX) ? SH_MAX : shift;
    shifted = ext << sh_amt;
    sh_full = (sh_amt == SH_MAX);
  end

endmodule

// File: rtl/acc_shsub_arith.sv
module acc_shsub_arith
  import acc_shsub_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic [ACC_W-1:0] acc_in,
  input  logic [ACC_W-1:0] sub_in,
  input  logic             sat_en,
  output logic [ACC_W-1:0] result,
  output logic             borrow,
  output ovf_kind_e        ovf_kind
);

  localparam int MSB = ACC_W - 1;
  localparam logic [ACC_W-1:0] SAT_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W:0]   diff;
  logic [ACC_W-1:0] wrapped;
  logic             pos_ovf;
  logic             neg_ovf;

  always_comb begin
    diff    = {1'b0, acc_in} - {1'b0, sub_in};
    wrapped = diff[MSB:0];
    borrow  = diff[ACC_W];
    pos_ovf = ~acc_in[MSB] &  sub_in[MSB] &  wrapped[MSB];
    neg_ovf =  acc_in[MSB] & ~sub_in[MSB] & ~wrapped[MSB];

    if (pos_ovf)      ovf_kind = OVF_POS;
    else if (neg_ovf) ovf_kind = OVF_NEG;
    else              ovf_kind = OVF_NONE;

    if (sat_en && pos_ovf)      result = SAT_POS;
    else if (sat_en && neg_ovf) result = SAT_NEG;
    else                        result = wrapped;
  end

endmodule

// File: rtl/acc_shsub_update.sv
module acc_shsub_update
  import acc_shsub_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OVC_W = 6
) (
  input  logic [ACC_W-1:0] result,
  input  logic             borrow,
  input  ovf_kind_e        ovf_kind,
  input  logic             sh_full,
  input  logic             sat_en,
  input  flags_t           flags_cur,
  input  logic [OVC_W-1:0] ovc_cur,
  output flags_t           flags_nxt,
  output logic [OVC_W-1:0] ovc_nxt
);

  logic any_ovf;

  always_comb begin
    any_ovf     = (ovf_kind != OVF_NONE);
    flags_nxt.z = (result == '0);
    flags_nxt.n = result[ACC_W-1];
    // full-width shift may only clear carry
    if (sh_full) flags_nxt.c = flags_cur.c & ~borrow;
    else         flags_nxt.c = ~borrow;
    flags_nxt.v = flags_cur.v | any_ovf;

    ovc_nxt = ovc_cur;
    if (!sat_en) begin
      if (ovf_kind == OVF_POS)      ovc_nxt = ovc_cur + OVC_W'(1);
      else if (ovf_kind == OVF_NEG) ovc_nxt = ovc_cur - OVC_W'(1);
    end
  end

endmodule

// File: rtl/acc_shsub.sv
module acc_shsub
  import acc_shsub_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OPD_W = 16,
  parameter int OVC_W = 6,
  localparam int SH_W = $clog2(OPD_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_vld,
  input  logic [OPD_W-1:0] op_data,
  input  logic [SH_W-1:0]  op_shift,
  input  logic             sext_en,
  input  logic             sat_en,
  input  logic             ld_vld,
  input  logic [ACC_W-1:0] ld_acc,
  input  logic             ld_z,
  input  logic             ld_n,
  input  logic             ld_c,
  input  logic             ld_v,
  input  logic [OVC_W-1:0] ld_ovc,
  output logic [ACC_W-1:0] acc,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_c,
  output logic             flag_v,
  output logic [OVC_W-1:0] ovf_cnt
);

  // reset: asserted at once, released two edges later
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic [ACC_W-1:0] acc_q, acc_d;
  flags_t           flg_q, flg_d;
  logic [OVC_W-1:0] ovc_q, ovc_d;
  logic             upd_en;

  logic [ACC_W-1:0] sub_val;
  logic             sh_full;
  logic [ACC_W-1:0] res_val;
  logic             borrow;
  ovf_kind_e        ovf_kind;
  flags_t           flg_op;
  logic [OVC_W-1:0] ovc_op;

  acc_shsub_shaper #(
    .ACC_W(ACC_W), .OPD_W(OPD_W), .SH_W(SH_W)
  ) u_shaper (
    .opd     (op_data),
    .shift   (op_shift),
    .sext_en (sext_en),
    .shifted (sub_val),
    .sh_full (sh_full)
  );

  acc_shsub_arith #(
    .ACC_W(ACC_W)
  ) u_arith (
    .acc_in   (acc_q),
    .sub_in   (sub_val),
    .sat_en   (sat_en),
    .result   (res_val),
    .borrow   (borrow),
    .ovf_kind (ovf_kind)
  );

  acc_shsub_update #(
    .ACC_W(ACC_W), .OVC_W(OVC_W)
  ) u_update (
    .result    (res_val),
    .borrow    (borrow),
    .ovf_kind  (ovf_kind),
    .sh_full   (sh_full),
    .sat_en    (sat_en),
    .flags_cur (flg_q),
    .ovc_cur   (ovc_q),
    .flags_nxt (flg_op),
    .ovc_nxt   (ovc_op)
  );

  // next-state selection: load wins over an operation
  always_comb begin
    upd_en = ld_vld | op_vld;
    if (ld_vld) begin
      acc_d   = ld_acc;
      flg_d.z = ld_z;
      flg_d.n = ld_n;
      flg_d.c = ld_c;
      flg_d.v = ld_v;
      ovc_d   = ld_ovc;
    end else begin
      acc_d = res_val;
      flg_d = flg_op;
      ovc_d = ovc_op;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      acc_q <= '0;
      flg_q <= '0;
      ovc_q <= '0;
    end else if (upd_en) begin
      acc_q <= acc_d;
      flg_q <= flg_d;
      ovc_q <= ovc_d;
    end
  end

  assign acc     = acc_q;
  assign flag_z  = flg_q.z;
  assign flag_n  = flg_q.n;
  assign flag_c  = flg_q.c;
  assign flag_v  = flg_q.v;
  assign ovf_cnt = ovc_q;

endmodule

// File: rtl/acc_shsub_chk.sv
module acc_shsub_chk #(
  parameter int ACC_W = 32,
  parameter int OVC_W = 6,
  parameter int SH_W  = 5,
  parameter int OPD_W = 16
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             op_vld,
  input logic [SH_W-1:0]  op_shift,
  input logic             sat_en,
  input logic             ld_vld,
  input logic [ACC_W-1:0] ld_acc,
  input logic             ld_v,
  input logic [OVC_W-1:0] ld_ovc,
  input logic [ACC_W-1:0] acc,
  input logic             flag_z,
  input logic             flag_n,
  input logic             flag_c,
  input logic             flag_v,
  input logic [OVC_W-1:0] ovf_cnt
);

  localparam logic [SH_W-1:0] SH_MAX = SH_W'(OPD_W);

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld_vld |=> (acc == $past(ld_acc)) && (ovf_cnt == $past(ld_ovc)) && (flag_v == $past(ld_v))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ld_vld && !op_vld) |=> $stable(acc) && $stable(ovf_cnt)
                             && $stable({flag_z, flag_n, flag_c, flag_v})); // R3

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_vld && !ld_vld) |=> (flag_z == (acc == '0))); // R6

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_vld && !ld_vld) |=> (flag_n == acc[ACC_W-1])); // R6

  AST_CARRY_SH16: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_vld && !ld_vld && (op_shift >= SH_MAX) && !flag_c) |=> !flag_c); // R8

  AST_V_STICKY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flag_v && !ld_vld) |=> flag_v); // R9

  AST_OVC_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_vld && !ld_vld && !sat_en) |=> (ovf_cnt == $past(ovf_cnt))
      || (ovf_cnt == $past(ovf_cnt) + OVC_W'(1))
      || (ovf_cnt == $past(ovf_cnt) - OVC_W'(1))); // R10

  AST_OVC_SAT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_vld && !ld_vld && sat_en) |=> $stable(ovf_cnt)); // R11

endmodule

bind acc_shsub acc_shsub_chk #(
  .ACC_W(ACC_W), .OVC_W(OVC_W), .SH_W(SH_W), .OPD_W(OPD_W)
) u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .op_vld   (op_vld),
  .op_shift (op_shift),
  .sat_en   (sat_en),
  .ld_vld   (ld_vld),
  .ld_acc   (ld_acc),
  .ld_v     (ld_v),
  .ld_ovc   (ld_ovc),
  .acc      (acc),
  .flag_z   (flag_z),
  .flag_n   (flag_n),
  .flag_c   (flag_c),
  .flag_v   (flag_v),
  .ovf_cnt  (ovf_cnt)
);

// File: tb/sim_acc_shsub.sv
`timescale 1ns/1ps
module sim_acc_shsub;

  logic        clk;
  logic        rst_n;
  logic        op_vld;
  logic [15:0] op_data;
  logic [4:0]  op_shift;
  logic        sext_en;
  logic        sat_en;
  logic        ld_vld;
  logic [31:0] ld_acc;
  logic        ld_z, ld_n, ld_c, ld_v;
  logic [5:0]  ld_ovc;
  logic [31:0] acc;
  logic        flag_z, flag_n, flag_c, flag_v;
  logic [5:0]  ovf_cnt;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // expected state
  logic [31:0] m_acc;
  logic        m_z, m_n, m_c, m_v;
  logic [5:0]  m_ovc;
  bit          m_ovf, m_sat, m_full;

  acc_shsub u0 (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_data(op_data),
    .op_shift(op_shift), .sext_en(sext_en), .sat_en(sat_en),
    .ld_vld(ld_vld), .ld_acc(ld_acc), .ld_z(ld_z), .ld_n(ld_n),
    .ld_c(ld_c), .ld_v(ld_v), .ld_ovc(ld_ovc), .acc(acc),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
    .ovf_cnt(ovf_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string acc_tag, input string c_tag);
    chk(acc_tag, "acc", acc, m_acc);
    chk("R6", "flag_z", 32'(flag_z), 32'(m_z));
    chk("R6", "flag_n", 32'(flag_n), 32'(m_n));
    chk(c_tag, "flag_c", 32'(flag_c), 32'(m_c));
    chk("R9", "flag_v", 32'(flag_v), 32'(m_v));
    chk(m_sat ? "R11" : "R10", "ovf_cnt", 32'(ovf_cnt), 32'(m_ovc));
  endtask

  // arithmetic model of one subtraction, in signed 64-bit terms
  task automatic model_op(input logic [15:0] d, input int sh, input bit sx, input bit sat);
    longint ext, shl, sa, ss, sd;
    logic [31:0] s32;
    int  eff;
    bit  pos, neg, brw;
    eff = (sh > 16) ? 16 : sh;
    ext = sx ? longint'($signed(d)) : longint'({48'd0, d});
    shl = ext * (longint'(1) << eff);
    s32 = shl[31:0];
    sa  = longint'($signed(m_acc));
    ss  = longint'($signed(s32));
    sd  = sa - ss;
    pos = sd > 64'sd2147483647;
    neg = sd < -64'sd2147483648;
    brw = ({32'd0, m_acc} < {32'd0, s32});
    if (sat && pos)      m_acc = 32'h7FFF_FFFF;
    else if (sat && neg) m_acc = 32'h8000_0000;
    else                 m_acc = sd[31:0];
    m_z = (m_acc == 32'd0);
    m_n = m_acc[31];
    if (eff == 16) m_c = brw ? 1'b0 : m_c;
    else           m_c = !brw;
    m_v = m_v | pos | neg;
    if (!sat) begin
      if (pos) m_ovc = m_ovc + 6'd1;
      if (neg) m_ovc = m_ovc - 6'd1;
    end
    m_ovf  = pos | neg;
    m_sat  = sat;
    m_full = (eff == 16);
  endtask

  task automatic do_load(input logic [31:0] a, input logic z, input logic n,
                         input logic c, input logic v, input logic [5:0] o);
    @(negedge clk);
    ld_vld = 1'b1; ld_acc = a; ld_z = z; ld_n = n; ld_c = c; ld_v = v; ld_ovc = o;
    @(negedge clk);
    ld_vld = 1'b0;
    m_acc = a; m_z = z; m_n = n; m_c = c; m_v = v; m_ovc = o;
  endtask

  task automatic do_op(input logic [15:0] d, input int sh, input bit sx, input bit sat);
    @(negedge clk);
    op_vld = 1'b1; op_data = d; op_shift = 5'(sh); sext_en = sx; sat_en = sat;
    @(negedge clk);
    op_vld = 1'b0;
    model_op(d, sh, sx, sat);
    // R4 covered through the accumulator value for each extension and shift
    chk((m_sat && m_ovf) ? "R11" : "R4/R5", "acc", acc, m_acc);
    chk("R6", "flag_z", 32'(flag_z), 32'(m_z));
    chk("R6", "flag_n", 32'(flag_n), 32'(m_n));
    chk(m_full ? "R8" : "R7", "flag_c", 32'(flag_c), 32'(m_c));
    chk("R9", "flag_v", 32'(flag_v), 32'(m_v));
    chk(m_sat ? "R11" : "R10", "ovf_cnt", 32'(ovf_cnt), 32'(m_ovc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [15:0] opds [6];
  logic [31:0] accs [6];

  initial begin
    rst_n = 1'b0; op_vld = 1'b0; op_data = '0; op_shift = '0; sext_en = 1'b0;
    sat_en = 1'b0; ld_vld = 1'b0; ld_acc = '0; ld_z = 1'b0; ld_n = 1'b0;
    ld_c = 1'b0; ld_v = 1'b0; ld_ovc = '0;
    opds = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h5A3C};
    accs = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
             32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
    repeat (3) @(negedge clk);
    m_acc = '0; m_z = 0; m_n = 0; m_c = 0; m_v = 0; m_ovc = '0; m_sat = 0;
    chk_all("R1", "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R1", "R1");

    // R2: load takes priority over a simultaneous operation
    @(negedge clk);
    ld_vld = 1'b1; ld_acc = 32'hDEAD_BEEF; ld_z = 1; ld_n = 0; ld_c = 1; ld_v = 1; ld_ovc = 6'h2A;
    op_vld = 1'b1; op_data = 16'h1111; op_shift = 5'd3;
    @(negedge clk);
    ld_vld = 1'b0; op_vld = 1'b0;
    m_acc = 32'hDEAD_BEEF; m_z = 1; m_n = 0; m_c = 1; m_v = 1; m_ovc = 6'h2A;
    chk_all("R2", "R2");

    // R3: inputs move but no strobe
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      op_data = 16'(k * 4097); op_shift = 5'(k); sext_en = k[0]; sat_en = k[1];
      ld_acc = 32'(k * 32'h0101_0101); ld_ovc = 6'(k);
      @(negedge clk);
      chk_all("R3", "R3");
    end

    // sweep of shift, modes, operand and accumulator corners
    for (int sx = 0; sx < 2; sx++)
      for (int sat = 0; sat < 2; sat++)
        for (int sh = 0; sh < 18; sh++)
          for (int oi = 0; oi < 6; oi++)
            for (int ai = 0; ai < 6; ai++)
              for (int c0 = 0; c0 < 2; c0++) begin
                do_load(accs[ai], 1'b0, 1'b0, c0[0], 1'b0, (oi[0]) ? 6'h1F : 6'h20);
                do_op(opds[oi], sh, sx[0], sat[0]);
              end

    // chained run without loads: counter wrap, sticky V, saturated flags
    do_load(32'h0000_0000, 1'b1, 1'b0, 1'b1, 1'b0, 6'h1E);
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      do_op(r[15:0], int'(r[20:16] % 5'd18), r[21], (k % 500) > 250);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule